// File: doc/BRIEF.md
# Multiply Operand Class Resolver

This combinational block settles the outcome of a floating-point multiply wherever the operand classes alone decide it, before any significand arithmetic takes place. Each of the two operands arrives unpacked, with a 3-bit class code, a sign, an exponent field and a significand field. The block returns an early result record in the same unpacked form, together with three flags. One flag marks the record as final. One reports an invalid operation. One passes the operation on to the significand multiplier.

Inside, each class code is first folded into a five-level rank. The two operands are then ordered by rank, so that the higher-ranked one (x) drives a single case table whatever the input order was. The record starts as a copy of x. The special-case rules then modify it. The sign becomes the XOR of the input signs unless the result is a NaN. When both operands are finite and non-zero, the copied record and the hand-off flag go to the multiplier stage. A pipeline places this block in front of that stage.

Top module: `mcr_mul_class_resolve`

## Requirements
- R1: The class rank is zero(0) < normal/subnormal(1) < infinity(2) < quiet NaN(3) < signaling NaN(4). Operand b is used as x whenever rank(a) <= rank(b), so equal ranks select b. Otherwise a is x. The exponent and significand of the record are those of x, except where R5 applies.
- R2: Class codes 5, 6 and 7 act exactly as signaling NaN (4), both for ordering and in the output class.
- R3: When the result class is zero, normal or infinity, the result sign equals a_sign XOR b_sign.
- R4: When x is a quiet or signaling NaN, the record is a copy of x, including its own sign. It is final and not invalid.
- R5: Infinity times zero sets the invalid flag and makes the result final. The record is the default quiet NaN: class 3, sign 0, exponent all ones, and a significand with only bit SIG_W-2 set.
- R6: Infinity times a normal or infinite operand gives final class infinity, with x's fields and no invalid flag.
- R7: Normal times zero gives final class zero, with x's exponent and significand.
- R8: The hand-off flag is high only when both operand classes are normal. In that case the final flag is low and the record carries x's fields. In every other case the final flag is high and the hand-off flag is low.
- R9: Zero times zero gives final class zero, with the XOR sign and b's fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_cls | input | 3 | Class code of operand a |
| a_sign | input | 1 | Sign of operand a |
| a_exp | input | EXP_W | Exponent field of operand a |
| a_sig | input | SIG_W | Significand field of operand a |
| b_cls | input | 3 | Class code of operand b |
| b_sign | input | 1 | Sign of operand b |
| b_exp | input | EXP_W | Exponent field of operand b |
| b_sig | input | SIG_W | Significand field of operand b |
| res_cls | output | 3 | Class of the early result |
| res_sign | output | 1 | Sign of the early result |
| res_exp | output | EXP_W | Exponent field of the early result |
| res_sig | output | SIG_W | Significand field of the early result |
| res_final | output | 1 | Record is the finished product |
| res_invalid | output | 1 | Invalid operation (infinity times zero) |
| mul_go | output | 1 | Both operands normal; hand off to the multiplier |

## Verification
The directed cases target equal-rank pairs, in particular two NaNs of the same class with different signs and payloads. A design that swaps only on strict inequality would return a's payload and sign instead of b's. Infinity times zero is tried in both operand orders, because a resolver that checks only one order would leak an infinity with no invalid flag. Class codes 5 to 7 are set against quiet NaNs: if codes above 4 were not folded into the signaling rank, the output class would be wrong, or the quiet operand would win the ordering. Random pairs from the whole code space confirm that NaN results keep their own sign while every other result takes the XOR sign.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
  localparam int CLS_W = 3;
  localparam logic [CLS_W-1:0] CLS_ZERO = 3'd0;
  localparam logic [CLS_W-1:0] CLS_NORM = 3'd1;
  localparam logic [CLS_W-1:0] CLS_INF  = 3'd2;
  localparam logic [CLS_W-1:0] CLS_QNAN = 3'd3;
  localparam logic [CLS_W-1:0] CLS_SNAN = 3'd4;
endpackage

// File: rtl/mcr_class_fold.sv
module mcr_class_fold
  import mcr_pkg::*;
(
  input  logic [CLS_W-1:0] raw_cls,
  output logic [CLS_W-1:0] rank_cls
);
  // Codes above the signaling code share its rank (R2).
  always_comb begin
    if (raw_cls > CLS_SNAN) rank_cls = CLS_SNAN;
    else                    rank_cls = raw_cls;
  end
endmodule

// File: rtl/mcr_order.sv
module mcr_order
  import mcr_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int SIG_W = 53
) (
  input  logic [CLS_W-1:0] a_cls,
  input  logic             a_sign,
  input  logic [EXP_W-1:0] a_exp,
  input  logic [SIG_W-1:0] a_sig,
  input  logic [CLS_W-1:0] b_cls,
  input  logic             b_sign,
  input  logic [EXP_W-1:0] b_exp,
  input  logic [SIG_W-1:0] b_sig,
  output logic [CLS_W-1:0] x_cls,
  output logic             x_sign,
  output logic [EXP_W-1:0] x_exp,
  output logic [SIG_W-1:0] x_sig,
  output logic [CLS_W-1:0] y_cls
);
  logic take_b;

  // Equal ranks also pick b (R1).
  assign take_b = (a_cls <= b_cls);

  always_comb begin
    if (take_b) begin
      x_cls  = b_cls;
      x_sign = b_sign;
      x_exp  = b_exp;
      x_sig  = b_sig;
      y_cls  = a_cls;
    end else begin
      x_cls  = a_cls;
      x_sign = a_sign;
      x_exp  = a_exp;
      x_sig  = a_sig;
      y_cls  = b_cls;
    end
  end

  // x never ranks below y after ordering.
  always_comb begin
    a_r1_x_ranks_high: assert (x_cls >= y_cls)
      else $error("R1: ordered x ranks below y");
  end
endmodule

// File: rtl/mcr_case_table.sv
module mcr_case_table
  import mcr_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int SIG_W = 53
) (
  input  logic [CLS_W-1:0] x_cls,
  input  logic             x_sign,
  input  logic [EXP_W-1:0] x_exp,
  input  logic [SIG_W-1:0] x_sig,
  input  logic [CLS_W-1:0] y_cls,
  input  logic             prod_sign,
  output logic [CLS_W-1:0] res_cls,
  output logic             res_sign,
  output logic [EXP_W-1:0] res_exp,
  output logic [SIG_W-1:0] res_sig,
  output logic             res_final,
  output logic             res_invalid,
  output logic             mul_go
);
  localparam logic [EXP_W-1:0] DQ_EXP = {EXP_W{1'b1}};
  localparam logic [SIG_W-1:0] DQ_SIG = {2'b01, {(SIG_W-2){1'b0}}};

  logic [CLS_W-1:0] cls_d;
  logic             sign_d;

  always_comb begin
    cls_d       = x_cls;
    sign_d      = x_sign;
    res_exp     = x_exp;
    res_sig     = x_sig;
    res_final   = 1'b1;
    res_invalid = 1'b0;
    mul_go      = 1'b0;
    case (x_cls)
      CLS_INF: begin
        if (y_cls == CLS_ZERO) begin
          cls_d       = CLS_QNAN;
          sign_d      = 1'b0;
          res_exp     = DQ_EXP;
          res_sig     = DQ_SIG;
          res_invalid = 1'b1;
        end
      end
      CLS_NORM: begin
        if (y_cls == CLS_ZERO) begin
          cls_d = CLS_ZERO;
        end else begin
          res_final = 1'b0;
          mul_go    = 1'b1;
        end
      end
      default: ;  // zero or NaN x: the copy stands
    endcase
  end

  // Non-NaN results take the product sign (R3).
  always_comb begin
    res_cls  = cls_d;
    res_sign = (cls_d < CLS_QNAN) ? prod_sign : sign_d;
  end
endmodule

// File: rtl/mcr_mul_class_resolve.sv
module mcr_mul_class_resolve
  import mcr_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int SIG_W = 53
) (
  input  logic [2:0]       a_cls,
  input  logic             a_sign,
  input  logic [EXP_W-1:0] a_exp,
  input  logic [SIG_W-1:0] a_sig,
  input  logic [2:0]       b_cls,
  input  logic             b_sign,
  input  logic [EXP_W-1:0] b_exp,
  input  logic [SIG_W-1:0] b_sig,
  output logic [2:0]       res_cls,
  output logic             res_sign,
  output logic [EXP_W-1:0] res_exp,
  output logic [SIG_W-1:0] res_sig,
  output logic             res_final,
  output logic             res_invalid,
  output logic             mul_go
);
  localparam int N_OPS = 2;

  logic [CLS_W-1:0] raw_cls  [N_OPS];
  logic [CLS_W-1:0] rank_cls [N_OPS];
  logic [CLS_W-1:0] x_cls, y_cls;
  logic             x_sign;
  logic [EXP_W-1:0] x_exp;
  logic [SIG_W-1:0] x_sig;

  assign raw_cls[0] = a_cls;
  assign raw_cls[1] = b_cls;

  for (genvar i = 0; i < N_OPS; i++) begin : g_fold
    mcr_class_fold u_fold (
      .raw_cls  (raw_cls[i]),
      .rank_cls (rank_cls[i])
    );
  end

  mcr_order #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_order (
    .a_cls  (rank_cls[0]),
    .a_sign (a_sign),
    .a_exp  (a_exp),
    .a_sig  (a_sig),
    .b_cls  (rank_cls[1]),
    .b_sign (b_sign),
    .b_exp  (b_exp),
    .b_sig  (b_sig),
    .x_cls  (x_cls),
    .x_sign (x_sign),
    .x_exp  (x_exp),
    .x_sig  (x_sig),
    .y_cls  (y_cls)
  );

  mcr_case_table #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_table (
    .x_cls       (x_cls),
    .x_sign      (x_sign),
    .x_exp       (x_exp),
    .x_sig       (x_sig),
    .y_cls       (y_cls),
    .prod_sign   (a_sign ^ b_sign),
    .res_cls     (res_cls),
    .res_sign    (res_sign),
    .res_exp     (res_exp),
    .res_sig     (res_sig),
    .res_final   (res_final),
    .res_invalid (res_invalid),
    .mul_go      (mul_go)
  );

  always_comb begin
    a_r8_final_xor_go: assert (res_final ^ mul_go)
      else $error("R8: final and hand-off not exclusive");
    a_r8_go_both_normal: assert (!mul_go || (a_cls == CLS_NORM && b_cls == CLS_NORM))
      else $error("R8: hand-off without two normal operands");
    a_r5_invalid_gives_qnan: assert (!res_invalid || (res_cls == CLS_QNAN && !res_sign))
      else $error("R5: invalid without default quiet NaN");
    a_r3_sign_rule: assert (res_cls >= CLS_QNAN || res_sign == (a_sign ^ b_sign))
      else $error("R3: non-NaN result sign differs from product sign");
    a_r2_class_in_range: assert (res_cls <= CLS_SNAN)
      else $error("R2: result class outside folded range");
  end
endmodule

// File: tb/sim_mcr_mul_class_resolve.sv
module sim_mcr_mul_class_resolve;
  localparam int EXP_W = 11;
  localparam int SIG_W = 53;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [2:0] a_cls, b_cls, res_cls;
  logic a_sign, b_sign, res_sign, res_final, res_invalid, mul_go;
  logic [EXP_W-1:0] a_exp, b_exp, res_exp;
  logic [SIG_W-1:0] a_sig, b_sig, res_sig;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  mcr_mul_class_resolve #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u0 (.*);

  function automatic logic [2:0] rk(input logic [2:0] c);
    return (c > 3'd4) ? 3'd4 : c;
  endfunction

  task automatic apply(input logic [2:0] ac, input logic as_, input logic [EXP_W-1:0] ae,
                       input logic [SIG_W-1:0] asg, input logic [2:0] bc, input logic bs,
                       input logic [EXP_W-1:0] be, input logic [SIG_W-1:0] bsg);
    logic [2:0] xc, yc, ec;
    logic xs, es, ef, ei, eg;
    logic [EXP_W-1:0] xe, ee;
    logic [SIG_W-1:0] xsg, esg;
    string tag;
    @(posedge clk);
    a_cls = ac; a_sign = as_; a_exp = ae; a_sig = asg;
    b_cls = bc; b_sign = bs;  b_exp = be; b_sig = bsg;
    // R1 ordering
    if (rk(ac) <= rk(bc)) begin xc = rk(bc); xs = bs; xe = be; xsg = bsg; yc = rk(ac); end
    else                  begin xc = rk(ac); xs = as_; xe = ae; xsg = asg; yc = rk(bc); end
    ec = xc; es = xs; ee = xe; esg = xsg; ef = 1; ei = 0; eg = 0; tag = "R1";
    if (xc >= 3) tag = (ac > 4 || bc > 4) ? "R2" : "R4";
    else if (xc == 0) tag = "R9";
    else if (xc == 2 && yc == 0) begin
      ec = 3; es = 0; ee = '1; esg = '0; esg[SIG_W-2] = 1'b1; ei = 1; tag = "R5";
    end else if (xc == 2) tag = "R6";
    else if (yc == 0) begin ec = 0; tag = "R7"; end
    else begin ef = 0; eg = 1; tag = "R8"; end
    if (ec < 3) es = as_ ^ bs;
    @(negedge clk);
    checks++;
    if (res_cls !== ec || res_sign !== es || res_exp !== ee || res_sig !== esg ||
        res_final !== ef || res_invalid !== ei || mul_go !== eg) begin
      errors++;
      $display("FAIL %s (R3 sign rule): a=%0d/%0b b=%0d/%0b got cls=%0d s=%0b e=%h m=%h f=%0b i=%0b g=%0b exp cls=%0d s=%0b e=%h m=%h f=%0b i=%0b g=%0b",
               tag, ac, as_, bc, bs, res_cls, res_sign, res_exp, res_sig, res_final,
               res_invalid, mul_go, ec, es, ee, esg, ef, ei, eg);
    end
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5eed_0042);
    a_cls = 0; b_cls = 0; a_sign = 0; b_sign = 0;
    a_exp = 0; b_exp = 0; a_sig = 0; b_sig = 0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // R9 quiescent state: zero times zero
    apply(0, 1, 11'h010, 53'h1, 0, 0, 11'h020, 53'h2);
    // R4 equal-rank NaNs pick b, keep b's sign
    apply(3, 0, 11'h7ff, 53'h11, 3, 1, 11'h7fe, 53'h22);
    apply(4, 1, 11'h7ff, 53'h33, 4, 0, 11'h7fd, 53'h44);
    // R2 codes 5..7 beat quiet NaN
    apply(3, 1, 11'h7ff, 53'h55, 6, 0, 11'h001, 53'h66);
    apply(7, 1, 11'h002, 53'h77, 3, 0, 11'h7ff, 53'h88);
    apply(5, 0, 11'h003, 53'h99, 4, 1, 11'h004, 53'haa);
    // R5 inf times zero, both orders
    apply(2, 1, 11'h7ff, 53'h0, 0, 0, 11'h0, 53'h0);
    apply(0, 1, 11'h0, 53'h5, 2, 1, 11'h7ff, 53'h0);
    // R6 inf times normal / inf
    apply(1, 1, 11'h123, 53'h1f, 2, 0, 11'h7ff, 53'h0);
    apply(2, 1, 11'h7ff, 53'h3, 2, 1, 11'h7fe, 53'h4);
    // R7 normal times zero, both orders
    apply(1, 0, 11'h400, 53'hbeef, 0, 1, 11'h0, 53'h0);
    apply(0, 0, 11'h0, 53'h0, 1, 1, 11'h3ff, 53'hcafe);
    // R8 normal times normal, R1 equal rank picks b
    apply(1, 1, 11'h111, 53'h1234, 1, 1, 11'h222, 53'h5678);
    // R3 via random mix
    for (int k = 0; k < 400; k++) begin
      apply($urandom % 8, $urandom % 2, EXP_W'($urandom), SIG_W'({$urandom, $urandom}),
            $urandom % 8, $urandom % 2, EXP_W'($urandom), SIG_W'({$urandom, $urandom}));
    end
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule